// File: doc/BRIEF.md
# Serial Write-Only Control Register Port

This block is the control front end of an audio converter. A host drives three lines: an active-low select, a serial clock and serial data. Each transaction carries 16 bits, most significant bit first. The first two bits are a device code, then one direction bit, then a 5-bit register index, then 8 data bits. The block oversamples the three lines with its own system clock. It shifts the bits in on rising serial-clock edges. When the select line rises, it commits the frame to a five-entry register file, but only if the frame is well formed.

The register file drives the converter's control fields directly:

- clock auto-detect, interface format, power enable and timing-run (index 0);
- sample-speed class, de-emphasis choice and soft mute (index 1);
- per-channel output inversion (index 2);
- left and right attenuation (indices 3 and 4).

A hardware power-down input holds every register at its default and blocks writes while it is low. There is no readback path.

Top module: `ctl_port`

## Requirements
- R1: After reset the registers hold index 0 = 8Bh, index 1 = 02h, index 2 = 00h, index 3 = FFh and index 4 = FFh. The fields are mapped as follows.
  - Index 0: bit 7 = `auto_clk`, bits 4:2 = `fmt_sel`, bit 1 = `pwr_en`, bit 0 = `run_en`.
  - Index 1: bits 4:3 = `speed_sel`, bits 2:1 = `deemph_sel`, bit 0 = `soft_mute`.
  - Index 2: bit 4 = `inv_left`, bit 3 = `inv_right`.
  - Index 3 is `att_left` and index 4 is `att_right`.
- R2: A frame takes effect only when `cs_n` rises. The outputs change on the third rising clock edge after the rise, and the frame has no effect while `cs_n` stays low.
- R3: The first two frame bits must be 01 and the third bit (write) must be 1. Any other combination discards the frame.
- R4: A frame with fewer or more than 16 serial-clock rising edges while `cs_n` is low is discarded.
- R5: Frames addressed to index 05h through 1Fh change no output.
- R6: While `pdn_n` is low all registers show their defaults, and frames sent during that time are lost.
- R7: Writing 0 to `pwr_en` or `run_en` leaves every other register unchanged, and later frames are still accepted.
- R8: Data bits in unused positions (index 0 bits 6:5, index 1 bits 7:5, index 2 bits 7:5 and 2:0) affect no output.
- R9: A valid frame to index 0 through 4 changes only the fields of that index, to the data bits sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Synchronous active-low reset |
| pdn_n | input | 1 | Power-down, active low, synchronous to clk |
| cs_n | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock, data taken on its rising edge |
| sdi | input | 1 | Serial data, MSB first |
| auto_clk | output | 1 | Clock auto-detect enable |
| fmt_sel | output | 3 | Audio interface format code |
| pwr_en | output | 1 | Power enable bit |
| run_en | output | 1 | Internal timing run bit |
| speed_sel | output | 2 | Sample-speed class |
| deemph_sel | output | 2 | De-emphasis choice |
| soft_mute | output | 1 | Soft mute request |
| inv_left | output | 1 | Left output polarity inversion |
| inv_right | output | 1 | Right output polarity inversion |
| att_left | output | 8 | Left attenuation level |
| att_right | output | 8 | Right attenuation level |

## Verification
Each serial line passes through two synchronizer flops and one edge-detect flop. A `cs_n` rise driven between clock edges therefore updates the outputs on the third rising edge after it. The bench checks both sides of that boundary: it samples two edges after the rise to see the old value and one edge later to see the new one. All other frame checks wait six clocks after the rise. `pdn_n` is sampled directly, so its effect is checked two clocks after it changes. Before every check, the expected field values come from a byte model in the bench that applies only accepted writes.

// File: rtl/ctl_pkg.sv
// Package: shared constants, frame layout and register reset/mask tables.
// Assumes a 16-bit frame of device code, write bit, index and data byte.
package ctl_pkg;
    localparam int DATA_W   = 8;
    localparam int ADDR_W   = 5;
    localparam int CHIP_W   = 2;
    localparam int NUM_REGS = 5;
    localparam int FRAME_W  = CHIP_W + 1 + ADDR_W + DATA_W;
    localparam logic [CHIP_W-1:0] CHIP_ID = 2'b01;

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wr_req_t;

    // Reset value of register idx
    function automatic logic [DATA_W-1:0] reg_default(input int idx);
        case (idx)
            0:       return 8'h8B;
            1:       return 8'h02;
            2:       return 8'h00;
            default: return 8'hFF;
        endcase
    endfunction

    // Bits that hold state in register idx; others read 0
    function automatic logic [DATA_W-1:0] reg_mask(input int idx);
        case (idx)
            0:       return 8'h9F;
            1:       return 8'h1F;
            2:       return 8'h18;
            default: return 8'hFF;
        endcase
    endfunction

    // Packed image of all registers at their defaults
    function automatic logic [NUM_REGS-1:0][DATA_W-1:0] default_image();
        logic [NUM_REGS-1:0][DATA_W-1:0] img;
        for (int i = 0; i < NUM_REGS; i++) img[i] = reg_default(i) & reg_mask(i);
        return img;
    endfunction
endpackage

// File: rtl/ctl_sync.sv
// Module: multi-stage synchronizer for a bundle of asynchronous inputs.
// Assumes each bit is independent; RST_VAL gives each bit's idle level.
module ctl_sync #(
    parameter int             W       = 3,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    // First stage captures the raw input
    always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= RST_VAL;
        else        stg[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        // Each later stage re-times the previous one
        always_ff @(posedge clk) begin
            if (!rst_n) stg[s] <= RST_VAL;
            else        stg[s] <= stg[s-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/ctl_frame_rx.sv
// Module: deserializes one frame while select is low and, on the select
// rising edge, presents a one-cycle write request if the frame is well formed.
// Assumes inputs are already synchronized to clk.
module ctl_frame_rx
    import ctl_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    cs_n_s,
    input  logic    sclk_s,
    input  logic    sdi_s,
    output wr_req_t req
);
    localparam int CNT_W   = $clog2(FRAME_W + 2);
    localparam int CNT_MAX = FRAME_W + 1;

    logic               cs_d, sclk_d;
    logic [FRAME_W-1:0] shift_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               sclk_rise, cs_rise;

    assign sclk_rise = sclk_s & ~sclk_d & ~cs_n_s;
    assign cs_rise   = cs_n_s & ~cs_d;

    // Edge history, shift register and saturating bit counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_d    <= 1'b1;
            sclk_d  <= 1'b1;
            shift_q <= '0;
            cnt_q   <= '0;
        end else begin
            cs_d   <= cs_n_s;
            sclk_d <= sclk_s;
            if (cs_n_s) begin
                cnt_q <= '0;
            end else if (sclk_rise) begin
                shift_q <= {shift_q[FRAME_W-2:0], sdi_s};
                if (cnt_q != CNT_W'(CNT_MAX)) cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // Frame check: exact length, device code and write bit
    always_comb begin
        req.addr  = shift_q[DATA_W +: ADDR_W];
        req.data  = shift_q[DATA_W-1:0];
        req.valid = cs_rise
                 && (cnt_q == CNT_W'(FRAME_W))
                 && (shift_q[FRAME_W-1 -: CHIP_W] == CHIP_ID)
                 && shift_q[DATA_W + ADDR_W];
    end

    AST_COUNT_CLEARS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |=> (cnt_q == '0));                               // R4
    AST_NO_REQ_WITHOUT_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n_s |-> !req.valid);                                 // R2
endmodule

// File: rtl/ctl_regs.sv
// Module: register file loaded by write requests; power-down forces defaults.
// Assumes at most one request per cycle; unmapped indices match no entry.
module ctl_regs
    import ctl_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             pdn_n,
    input  wr_req_t                          req,
    output logic [NUM_REGS-1:0][DATA_W-1:0]  regs_o
);
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        logic [DATA_W-1:0] r_q;

        // Hold, load a matching write, or return to default
        always_ff @(posedge clk) begin
            if (!rst_n || !pdn_n)
                r_q <= reg_default(g) & reg_mask(g);
            else if (req.valid && req.addr == ADDR_W'(g))
                r_q <= req.data & reg_mask(g);
        end

        assign regs_o[g] = r_q;
    end

    AST_PDN_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        !pdn_n |=> (regs_o == default_image()));                 // R6
    AST_HOLD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (pdn_n && !req.valid) |=> $stable(regs_o));              // R2
    AST_UNMAPPED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (pdn_n && req.valid && req.addr >= ADDR_W'(NUM_REGS)) |=> $stable(regs_o)); // R5
endmodule

// File: rtl/ctl_port.sv
// Module: top of the serial write-only control port. Synchronizes the three
// serial lines, decodes frames and drives the control fields.
// Assumes the serial clock is well below half the system clock rate.
module ctl_port
    import ctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pdn_n,
    input  logic       cs_n,
    input  logic       sclk,
    input  logic       sdi,
    output logic       auto_clk,
    output logic [2:0] fmt_sel,
    output logic       pwr_en,
    output logic       run_en,
    output logic [1:0] speed_sel,
    output logic [1:0] deemph_sel,
    output logic       soft_mute,
    output logic       inv_left,
    output logic       inv_right,
    output logic [7:0] att_left,
    output logic [7:0] att_right
);
    localparam int SYNC_STAGES = 2;

    logic [2:0]                      line_s;
    wr_req_t                         req;
    logic [NUM_REGS-1:0][DATA_W-1:0] regs;

    ctl_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cs_n, sclk, sdi}),
        .q     (line_s)
    );

    ctl_frame_rx u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs_n_s (line_s[2]),
        .sclk_s (line_s[1]),
        .sdi_s  (line_s[0]),
        .req    (req)
    );

    ctl_regs u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .pdn_n  (pdn_n),
        .req    (req),
        .regs_o (regs)
    );

    // Field decode of the register images
    assign auto_clk   = regs[0][7];
    assign fmt_sel    = regs[0][4:2];
    assign pwr_en     = regs[0][1];
    assign run_en     = regs[0][0];
    assign speed_sel  = regs[1][4:3];
    assign deemph_sel = regs[1][2:1];
    assign soft_mute  = regs[1][0];
    assign inv_left   = regs[2][4];
    assign inv_right  = regs[2][3];
    assign att_left   = regs[3];
    assign att_right  = regs[4];

    AST_ATT_STABLE_WHILE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (pdn_n && $past(pdn_n) && !line_s[2] && !$past(line_s[2]))
            |-> $stable(att_left) && $stable(att_right));        // R2
endmodule

// File: tb/ctl_port_test.sv
// Bench: sweeps every index and frame variant and compares the fields
// against a byte model of accepted writes.
module ctl_port_test;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n, pdn_n, cs_n, sclk, sdi;
    logic auto_clk, pwr_en, run_en, soft_mute, inv_left, inv_right;
    logic [2:0] fmt_sel;
    logic [1:0] speed_sel, deemph_sel;
    logic [7:0] att_left, att_right;

    ctl_port uut (
        .clk(clk), .rst_n(rst_n), .pdn_n(pdn_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
        .auto_clk(auto_clk), .fmt_sel(fmt_sel), .pwr_en(pwr_en), .run_en(run_en),
        .speed_sel(speed_sel), .deemph_sel(deemph_sel), .soft_mute(soft_mute),
        .inv_left(inv_left), .inv_right(inv_right), .att_left(att_left), .att_right(att_right)
    );

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] mdl [5];

    wire [28:0] obs = {auto_clk, fmt_sel, pwr_en, run_en, speed_sel, deemph_sel,
                       soft_mute, inv_left, inv_right, att_left, att_right};

    function automatic logic [28:0] expv();
        return {mdl[0][7], mdl[0][4:2], mdl[0][1], mdl[0][0], mdl[1][4:3], mdl[1][2:1],
                mdl[1][0], mdl[2][4], mdl[2][3], mdl[3], mdl[4]};
    endfunction

    task automatic check(input string tag);
        n_chk++;
        if (obs !== expv()) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, obs, expv());
        end
    endtask

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic model_defaults();
        mdl[0] = 8'h8B; mdl[1] = 8'h02; mdl[2] = 8'h00; mdl[3] = 8'hFF; mdl[4] = 8'hFF;
    endtask

    // Shift n bits MSB first; optionally leave select low afterwards
    task automatic shift_bits(input logic [31:0] bits, input int n, input bit close);
        cs_n = 1'b0;
        ticks(4);
        for (int i = n - 1; i >= 0; i--) begin
            sclk = 1'b0; sdi = bits[i];
            ticks(4);
            sclk = 1'b1;
            ticks(4);
        end
        ticks(4);
        if (close) begin
            cs_n = 1'b1;
            ticks(6);
        end
    endtask

    task automatic write(input logic [4:0] a, input logic [7:0] d);
        shift_bits({16'h0, 2'b01, 1'b1, a, d}, 16, 1'b1);
        if (a < 5) mdl[a] = d;
    endtask

    initial begin
        #(200000 * 20);
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; pdn_n = 1'b1; cs_n = 1'b1; sclk = 1'b1; sdi = 1'b0;
        model_defaults();
        ticks(3);
        rst_n = 1'b1;
        ticks(2);
        check("R1 reset defaults");

        // R9 / R5: every index 0..31 with a varying data byte
        for (int a = 0; a < 32; a++) begin
            write(5'(a), 8'((a * 53 + 17) & 8'hFF));
            check(a < 5 ? "R9 indexed write" : "R5 unmapped index");
        end

        // R8: all-ones data, unused bits must not show
        write(5'd0, 8'hFF); write(5'd1, 8'hFF); write(5'd2, 8'hFF);
        check("R8 unused bits");
        write(5'd2, 8'hE7);
        check("R8 unused bits index 2");

        // R2: no effect while select is low, exact latency after its rise
        write(5'd3, 8'h11);
        shift_bits({16'h0, 2'b01, 1'b1, 5'd3, 8'h5A}, 16, 1'b0);
        check("R2 before select rise");
        cs_n = 1'b1;
        ticks(2);
        check("R2 two edges after rise");
        mdl[3] = 8'h5A;
        ticks(1);
        check("R2 third edge after rise");
        ticks(4);

        // R3: every wrong device-code / write-bit combination
        for (int c = 0; c < 8; c++) begin
            if (c != 3) begin
                shift_bits({16'h0, 3'(c), 5'd4, 8'h3C}, 16, 1'b1);
                check("R3 header mismatch");
            end
        end

        // R4: short and long frames
        shift_bits({17'h0, 2'b01, 1'b1, 5'd4, 7'h21}, 15, 1'b1);
        check("R4 fifteen bits");
        shift_bits({15'h0, 1'b1, 2'b01, 1'b1, 5'd4, 8'h66}, 17, 1'b1);
        check("R4 seventeen bits");
        write(5'd4, 8'h66);
        check("R4 sixteen bits accepted");

        // R7: clearing power and run bits keeps others, port stays writable
        write(5'd0, 8'h88);
        check("R7 clear pwr/run");
        write(5'd3, 8'h0F);
        check("R7 still writable");

        // R6: power-down restores defaults and blocks writes
        pdn_n = 1'b0;
        ticks(2);
        model_defaults();
        check("R6 defaults in power-down");
        shift_bits({16'h0, 2'b01, 1'b1, 5'd4, 8'h00}, 16, 1'b1);
        check("R6 write blocked");
        pdn_n = 1'b1;
        ticks(2);
        check("R6 after power-down release");
        write(5'd4, 8'h42);
        check("R6 writable after release");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule